// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

The sequencer turns one accepted request into one external memory access on a parallel address and data port. Each access is a run of four phases, one clock each. In the first phase the address and the two-bit space select are presented. The transfer strobe is active in the middle phases. The last phase closes the access. The third phase repeats once for each wait state. The number of repeats is the larger of a programmed minimum and the number of clocks during which the external device holds its acknowledge low.

Read data is captured as the transfer strobe is released and is returned together with a one-clock done pulse. Writes drive the data port only while the transfer strobe is, or has just been, active. Between accesses the address holds its last value, the space select shows "no access" and the direction line shows read. An indivisible read-modify-write is issued as a read request and then a write request, both flagged as locked. The bus lock output stays active from the start of the read until the end of the write. A separate hold input forces the lock on at any time.

Top module: `bus_cycle_seq`

## Requirements
- R1: An accepted request produces phases P0..P3, one clock each when there are no wait states. `bus_strobe_n` is low in P0, P1 and P2, including repeats. `xfer_strobe_n` is low in P1 and P2. Both are high in P3.
- R2: The number of wait states W is the maximum of `wait_min`, which is sampled at acceptance, and the acknowledge lag. The access then lasts 4+W clocks, and phase P2 repeats W extra times.
- R3: `xfer_ack` is active high and is sampled at the end of every P2 clock. The access enters P3 on the clock after the one in which `xfer_ack` is high and the minimum count is used up. `xfer_ack` is ignored in all other phases.
- R4: `bus_space_n` is 2'b10 for program space (`req_space`=0), 2'b01 for X space (1) and 2'b00 for Y space (2 or 3) during the access. It is 2'b11 whenever no access is in progress.
- R5: `bus_addr` takes the request address in P0. It stays stable through P3 and keeps its value while idle.
- R6: `bus_rd_wr_n` is 1 for a read and 0 for a write during the access, and 1 when idle. `bus_wdata_oe` is 1 only in P1 to P3 of a write, and `bus_wdata` then carries the write data.
- R7: `done` is high for exactly the P3 clock of each access. In that clock `rd_data` holds the `bus_rdata` value sampled on the edge where `xfer_strobe_n` rises.
- R8: `bus_lock_n` goes low from P0 of a read with `req_rmw`=1. It stays low through any idle gap and rises after P3 of the next write with `req_rmw`=1.
- R9: While `lock_hold` is 1, `bus_lock_n` is 0 whatever the bus is doing.
- R10: `req_ready` is 1 when idle and in P3. A request with `req_ready`=0 is ignored. A request accepted in P3 starts P0 on the next clock, so back-to-back accesses with no wait states take four clocks each.
- R11: After synchronous reset the sequencer is idle: strobes, lock and direction are high, the space select is 11, `done` and `bus_wdata_oe` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request will be accepted this clock |
| req_space | input | 2 | 0 program, 1 X, 2/3 Y |
| req_write | input | 1 | 1 write, 0 read |
| req_rmw | input | 1 | Member of a locked read-modify-write pair |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| wait_min | input | WAIT_W | Programmed minimum wait states |
| lock_hold | input | 1 | Force bus lock active |
| xfer_ack | input | 1 | Synchronous transfer acknowledge, active high |
| bus_addr | output | ADDR_W | External address |
| bus_space_n | output | 2 | Space select, active low coded |
| bus_rd_wr_n | output | 1 | 1 read / 0 write |
| bus_strobe_n | output | 1 | Bus cycle strobe, active low |
| xfer_strobe_n | output | 1 | Transfer strobe, active low |
| bus_lock_n | output | 1 | Bus lock, active low |
| bus_wdata | output | DATA_W | Write data to the port |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DATA_W | Read data from the port |
| done | output | 1 | Access complete pulse |
| rd_data | output | DATA_W | Captured read data |

## Verification
The assertions assume that `xfer_ack` and the request inputs change only away from the rising edge. They also assume that a locked write always follows its locked read. The bench drives every input on the falling edge, and it raises acknowledge only after the chosen number of P2 clocks. It issues locked requests only as read-then-write pairs, and it changes `wait_min` only while idle.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_P0   = 3'd1,
        PH_P1   = 3'd2,
        PH_P2   = 3'd3,
        PH_P3   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [1:0] space;
        logic       write;
        logic       rmw;
    } acc_ctl_t;

    localparam logic [1:0] SEL_NONE = 2'b11;

    function automatic logic [1:0] space_code(input logic [1:0] sp);
        case (sp)
            2'd0:    space_code = 2'b10;
            2'd1:    space_code = 2'b01;
            default: space_code = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/bus_wait_ctr.sv
module bus_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              step,
    output logic              zero
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !zero && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bus_lock_trk.sv
module bus_lock_trk (
    input  logic clk,
    input  logic rst,
    input  logic start_rmw_rd,
    input  logic end_rmw_wr,
    input  logic lock_hold,
    output logic bus_lock_n
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (start_rmw_rd)
            lock_q <= 1'b1;
        else if (end_rmw_wr)
            lock_q <= 1'b0;
    end

    assign bus_lock_n = !(lock_q || lock_hold);

    assert_lock_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> $past(end_rmw_wr));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_space,
    input  logic              req_write,
    input  logic              req_rmw,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] wait_min,
    input  logic              lock_hold,
    input  logic              xfer_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_space_n,
    output logic              bus_rd_wr_n,
    output logic              bus_strobe_n,
    output logic              xfer_strobe_n,
    output logic              bus_lock_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    phase_e            state_q, state_d;
    acc_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              accept, wait_zero, in_wait, leave_wait;

    assign req_ready  = (state_q == PH_IDLE) || (state_q == PH_P3);
    assign accept     = req_valid && req_ready;
    assign in_wait    = (state_q == PH_P2);
    assign leave_wait = in_wait && wait_zero && xfer_ack;

    bus_wait_ctr #(.WAIT_W(WAIT_W)) wait_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (wait_min),
        .step     (in_wait),
        .zero     (wait_zero)
    );

    bus_lock_trk lock_i (
        .clk          (clk),
        .rst          (rst),
        .start_rmw_rd (accept && req_rmw && !req_write),
        .end_rmw_wr   ((state_q == PH_P3) && ctl_q.rmw && ctl_q.write),
        .lock_hold    (lock_hold),
        .bus_lock_n   (bus_lock_n)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            PH_IDLE: if (accept) state_d = PH_P0;
            PH_P0:   state_d = PH_P1;
            PH_P1:   state_d = PH_P2;
            PH_P2:   if (leave_wait) state_d = PH_P3;
            PH_P3:   state_d = accept ? PH_P0 : PH_IDLE;
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            ctl_q   <= '{space: 2'd0, write: 1'b0, rmw: 1'b0};
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ctl_q   <= '{space: req_space, write: req_write, rmw: req_rmw};
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (leave_wait && !ctl_q.write)
                rdata_q <= bus_rdata;
        end
    end

    assign bus_addr      = addr_q;
    assign bus_space_n   = (state_q == PH_IDLE) ? SEL_NONE : space_code(ctl_q.space);
    assign bus_rd_wr_n   = (state_q == PH_IDLE) ? 1'b1 : !ctl_q.write;
    assign bus_strobe_n  = !((state_q == PH_P0) || (state_q == PH_P1) || (state_q == PH_P2));
    assign xfer_strobe_n = !((state_q == PH_P1) || (state_q == PH_P2));
    assign bus_wdata     = wdata_q;
    assign bus_wdata_oe  = ctl_q.write && ((state_q == PH_P1) || (state_q == PH_P2) || (state_q == PH_P3));
    assign done          = (state_q == PH_P3);
    assign rd_data       = rdata_q;

    assert_strobe_order_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_strobe_n) |-> !bus_strobe_n);

    assert_min_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (in_wait && state_d == PH_P3) |-> wait_zero);

    assert_ack_seen_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_P3 && $past(state_q) == PH_P2) |-> $past(xfer_ack));

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_P1 || state_q == PH_P2 || state_q == PH_P3) |-> $stable(bus_addr));

    assert_dir_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_P1 || state_q == PH_P2 || state_q == PH_P3) |-> $stable(bus_rd_wr_n));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_rmw, lock_hold, xfer_ack;
    logic [1:0]  req_space, bus_space_n;
    logic [31:0] req_addr, req_wdata, bus_addr, bus_wdata, bus_rdata, rd_data;
    logic [3:0]  wait_min;
    logic        bus_rd_wr_n, bus_strobe_n, xfer_strobe_n, bus_lock_n, bus_wdata_oe, done;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] RD_MASK = 32'hC3C3_5A5A;

    always #5 clk = ~clk;

    assign bus_rdata = bus_addr ^ RD_MASK;

    bus_cycle_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_space(req_space), .req_write(req_write), .req_rmw(req_rmw),
        .req_addr(req_addr), .req_wdata(req_wdata), .wait_min(wait_min),
        .lock_hold(lock_hold), .xfer_ack(xfer_ack), .bus_addr(bus_addr),
        .bus_space_n(bus_space_n), .bus_rd_wr_n(bus_rd_wr_n),
        .bus_strobe_n(bus_strobe_n), .xfer_strobe_n(xfer_strobe_n),
        .bus_lock_n(bus_lock_n), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata(bus_rdata), .done(done), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [1:0]  sp;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [3:0]  wmin;
        logic [3:0]  ackd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'h0000_1000, 32'h0,         4'd0, 4'd0},
        '{2'd1, 1'b1, 32'h0000_2004, 32'hDEAD_BEEF, 4'd0, 4'd0},
        '{2'd2, 1'b0, 32'h0001_0008, 32'h0,         4'd2, 4'd0},
        '{2'd1, 1'b0, 32'h8000_000C, 32'h0,         4'd0, 4'd3},
        '{2'd0, 1'b1, 32'h1234_5670, 32'h0BAD_F00D, 4'd3, 4'd1},
        '{2'd2, 1'b1, 32'hFFFF_FFFC, 32'h5555_AAAA, 4'd1, 4'd4},
        '{2'd1, 1'b0, 32'h0F0F_0F00, 32'h0,         4'd5, 4'd5},
        '{2'd3, 1'b0, 32'h0000_0040, 32'h0,         4'd0, 4'd1}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [1:0] sp);
        if (sp == 2'd0) return 2'b10;
        if (sp == 2'd1) return 2'b01;
        return 2'b00;
    endfunction

    // Issue one access and check it phase by phase; returns at the negedge of P3.
    task automatic run_access(input logic [1:0] sp, input logic wr, input logic rmw,
                              input logic [31:0] addr, input logic [31:0] wd,
                              input logic [3:0] wmin, input int ackd, input logic exp_lock_n);
        int w;
        int last;
        w = (int'(wmin) > ackd) ? int'(wmin) : ackd;
        last = 3 + w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_space = sp; req_write = wr; req_rmw = rmw;
        req_addr = addr; req_wdata = wd; wait_min = wmin; xfer_ack = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int p = 0; p <= last; p++) begin
            if (p > 0) @(negedge clk);
            xfer_ack = (p >= 2 + ackd);
            chk(done == (p == last), "R2 done phase", {31'd0, done}, {31'd0, p == last});
            if (p == 0) begin
                chk(bus_space_n == exp_code(sp), "R4 space code", {30'd0, bus_space_n}, {30'd0, exp_code(sp)});
                chk(bus_addr == addr, "R5 address", bus_addr, addr);
                chk(bus_rd_wr_n == !wr, "R6 direction", {31'd0, bus_rd_wr_n}, {31'd0, !wr});
                chk(!bus_strobe_n && xfer_strobe_n, "R1 P0 strobes", {30'd0, bus_strobe_n, xfer_strobe_n}, 32'h1);
            end
            if (p == 1) begin
                chk(!bus_strobe_n && !xfer_strobe_n, "R1 P1 strobes", {30'd0, bus_strobe_n, xfer_strobe_n}, 32'h0);
                chk(bus_wdata_oe == wr, "R6 drive enable", {31'd0, bus_wdata_oe}, {31'd0, wr});
                if (wr) chk(bus_wdata == wd, "R6 write data", bus_wdata, wd);
            end
            if (p == last) begin
                chk(bus_strobe_n && xfer_strobe_n, "R1 P3 strobes", {30'd0, bus_strobe_n, xfer_strobe_n}, 32'h3);
                chk(bus_addr == addr, "R5 address held", bus_addr, addr);
                if (!wr) chk(rd_data == (addr ^ RD_MASK), "R7 read data", rd_data, addr ^ RD_MASK);
            end
            chk(bus_lock_n == exp_lock_n, "R8 lock level", {31'd0, bus_lock_n}, {31'd0, exp_lock_n});
        end
        xfer_ack = 1'b0;
    endtask

    task automatic chk_idle(input logic [31:0] addr);
        chk(bus_space_n == 2'b11, "R4 idle space", {30'd0, bus_space_n}, 32'h3);
        chk(bus_rd_wr_n && !bus_wdata_oe, "R6 idle dir/drive", {30'd0, bus_rd_wr_n, bus_wdata_oe}, 32'h2);
        chk(bus_addr == addr, "R5 idle address", bus_addr, addr);
        chk(!done, "R7 idle done", {31'd0, done}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_space = 2'd0; req_write = 1'b0; req_rmw = 1'b0;
        req_addr = '0; req_wdata = '0; wait_min = '0; lock_hold = 1'b0; xfer_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state
        @(negedge clk);
        chk(bus_strobe_n && xfer_strobe_n && bus_lock_n && bus_rd_wr_n, "R11 strobes high",
            {28'd0, bus_strobe_n, xfer_strobe_n, bus_lock_n, bus_rd_wr_n}, 32'hF);
        chk(bus_space_n == 2'b11 && !done && !bus_wdata_oe && req_ready, "R11 idle outputs",
            {26'd0, bus_space_n, done, bus_wdata_oe, req_ready, 1'b0}, {26'd0, 2'b11, 3'b001, 1'b0});

        // R1 R2 R3 R4 R6 R7: table walk
        for (int i = 0; i < NV; i++) begin
            run_access(VECS[i].sp, VECS[i].wr, 1'b0, VECS[i].addr, VECS[i].wd,
                       VECS[i].wmin, int'(VECS[i].ackd), 1'b1);
            @(negedge clk);
            chk_idle(VECS[i].addr);
        end

        // R10 back-to-back, second request ignored until ready
        begin
            int gap;
            @(negedge clk);
            wait_min = 4'd0; xfer_ack = 1'b1; req_rmw = 1'b0; req_write = 1'b0;
            req_valid = 1'b1; req_space = 2'd1; req_addr = 32'hA000_0000;
            @(negedge clk);
            req_addr = 32'hB000_0000; req_space = 2'd2;
            for (int p = 0; p < 3; p++) begin
                if (p > 0) @(negedge clk);
                chk(bus_addr == 32'hA000_0000, "R10 busy request ignored", bus_addr, 32'hA000_0000);
            end
            @(negedge clk);
            chk(done && req_ready, "R10 first done/ready", {30'd0, done, req_ready}, 32'h3);
            @(negedge clk);
            req_valid = 1'b0;
            chk(bus_addr == 32'hB000_0000 && bus_space_n == 2'b00, "R10 second starts at once",
                bus_addr, 32'hB000_0000);
            gap = 1;
            while (!done && gap < 20) begin @(negedge clk); gap++; end
            chk(gap == 4, "R10 back-to-back length", gap, 4);
            xfer_ack = 1'b0;
            @(negedge clk);
            chk_idle(32'hB000_0000);
        end

        // R8 locked read-modify-write pair with an idle gap
        run_access(2'd1, 1'b0, 1'b1, 32'h0000_3000, 32'h0, 4'd1, 0, 1'b0);
        repeat (2) begin
            @(negedge clk);
            chk(!bus_lock_n, "R8 lock held in gap", {31'd0, bus_lock_n}, 32'h0);
        end
        run_access(2'd1, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_0077, 4'd0, 2, 1'b0);
        @(negedge clk);
        chk(bus_lock_n, "R8 lock released", {31'd0, bus_lock_n}, 32'h1);

        // R9 lock hold forces lock during idle and plain access
        lock_hold = 1'b1;
        @(negedge clk);
        chk(!bus_lock_n, "R9 hold idle", {31'd0, bus_lock_n}, 32'h0);
        run_access(2'd0, 1'b0, 1'b0, 32'h0000_0100, 32'h0, 4'd0, 0, 1'b0);
        @(negedge clk);
        lock_hold = 1'b0;
        @(negedge clk);
        chk(bus_lock_n, "R9 hold removed", {31'd0, bus_lock_n}, 32'h1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule